// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is the operand stack of a zero-address processor. A command stream pushes immediates, pops, and applies add, subtract, multiply and divide, each binary operator taking its two operands implicitly from the top of the stack and leaving one result there. Only the uppermost `NREG` entries are held in a small circular register buffer. Anything deeper is kept in an upward-growing region of an external single-port synchronous memory, addressed by an internal memory stack pointer.

Memory is used only when the register part cannot serve a command. A push that finds every register slot occupied first writes the deepest register-resident entry out. A binary operator that finds fewer than two operands in registers reads them back one at a time. A parameter selects the refill policy: lazy, where a read happens only when an operator actually needs an operand, or eager, where after each command the block refills until two entries are register-resident or memory is empty. Store and fetch counters expose the memory traffic each policy causes, so that register depths and policies can be compared on real expression streams.

Commands use a valid/ready handshake. A command that needs no memory completes on its accepting edge. One that needs memory drops `cmd_ready` until its transfers and its own effect are complete.

Top module: `stack_cache_unit`

## Requirements
- R1: Opcode 0 pushes `cmd_data` onto the stack, and opcode 1 removes the top entry. `tos_data` shows the top entry whenever it is register-resident, with `tos_valid` high. Opcodes 6 and 7 change nothing.
- R2: Opcodes 2 (add), 3 (subtract), 4 (multiply) and 5 (divide) use unsigned arithmetic, keep the low `DW` bits, and compute next-to-top op top. For example, pushing x and then y and then subtracting yields x - y. The two operands are replaced by the single result.
- R3: Division by zero produces a result with every bit set.
- R4: A push with fewer than `NREG` register entries makes no memory access. A push with all `NREG` slots full writes the deepest register entry to address `sp`, increments `sp`, and then places the new value on top.
- R5: With lazy refill (`EAGER_FILL`=0), memory is read only when a binary operator has fewer than two operands in registers and memory is non-empty. Each read uses address `sp`-1 and decrements `sp` first. A pop with no register entries discards the memory top without reading it.
- R6: With eager refill (`EAGER_FILL`=1), after any command leaves fewer than two register entries while memory is non-empty, the block reads memory until two entries are register-resident or memory is empty, before signalling ready again.
- R7: A pop on an empty stack, or a binary operator with fewer than two entries in total, sets a sticky `underflow` flag and leaves the stack contents and depth unchanged.
- R8: `cmd_ready` is low in every cycle in which a memory access is made, and a command that needs memory takes effect before `cmd_ready` rises again.
- R9: `store_count` and `fetch_count` increment by one for every memory write and every memory read respectively.
- R10: For the stream a b c * + a d c * + e - /, the memory traffic is 3 stores and 3 fetches with `NREG`=2 and lazy refill, 4 and 4 with `NREG`=2 and eager refill, and none with `NREG`=4.
- R11: `stk_depth` equals the total number of stack entries, both register-resident and in memory.
- R12: After reset the stack is empty, `cmd_ready` is high, and `underflow` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted on this edge when high |
| cmd_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div |
| cmd_data | input | DW | Immediate for push |
| tos_data | output | DW | Top entry (zero when not register-resident) |
| tos_valid | output | 1 | Top entry is held in registers |
| stk_depth | output | AW+1 | Total stack entries |
| underflow | output | 1 | Sticky underflow flag |
| store_count | output | CNTW | Memory writes since reset |
| fetch_count | output | CNTW | Memory reads since reset |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after a read |

## Verification
A wrong head index or occupancy count shows up at once in `tos_data` or `stk_depth`. If it is hidden by a command that rewrites the top, it still appears as a wrong arithmetic result after the next operator that reaches a deeper entry. A wrong memory pointer or fill slot stays silent until an operator consumes a refilled operand, and then surfaces as a wrong result, with subtract and divide exposing swapped operand order. A misjudged spill or refill condition is seen within a single command as a change in `store_count` or `fetch_count`, and the full expression stream checks the traffic totals of every configuration.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SPILL = 3'd1,
        ST_FREQ  = 3'd2,
        ST_FCAP  = 3'd3,
        ST_EXEC  = 3'd4
    } st_e;

    function automatic logic is_binary(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] nos,
    input  logic [DW-1:0] top,
    output logic [DW-1:0] res
);

    always_comb begin
        case (op)
            OP_ADD:  res = nos + top;
            OP_SUB:  res = nos - top;
            OP_MUL:  res = nos * top;
            OP_DIV:  res = (top == '0) ? '1 : nos / top;
            default: res = top;
        endcase
    end

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
    parameter int DEPTH = 4,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] ra_top,
    input  logic [$clog2(DEPTH)-1:0] ra_nos,
    input  logic [$clog2(DEPTH)-1:0] ra_bot,
    output logic [DW-1:0]            rd_top,
    output logic [DW-1:0]            rd_nos,
    output logic [DW-1:0]            rd_bot
);

    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] ent [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [DW-1:0] val_d, val_q;
        always_comb val_d = (we && waddr == IW'(e)) ? wdata : val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end
        assign ent[e] = val_q;
    end

    assign rd_top = ent[ra_top];
    assign rd_nos = ent[ra_nos];
    assign rd_bot = ent[ra_bot];

endmodule

// File: rtl/stk_counter.sv
module stk_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = inc ? cnt_q + W'(1) : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/stack_cache_unit.sv
module stack_cache_unit
    import stk_pkg::*;
#(
    parameter int DW         = 16,
    parameter int NREG       = 4,
    parameter int AW         = 8,
    parameter int CNTW       = 16,
    parameter int EAGER_FILL = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [2:0]      cmd_op,
    input  logic [DW-1:0]   cmd_data,
    output logic [DW-1:0]   tos_data,
    output logic            tos_valid,
    output logic [AW:0]     stk_depth,
    output logic            underflow,
    output logic [CNTW-1:0] store_count,
    output logic [CNTW-1:0] fetch_count,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);

    localparam int IW   = $clog2(NREG);
    localparam int CW   = $clog2(NREG + 1);
    localparam int DEPW = AW + 1;

    typedef struct packed {
        st_e           st;
        logic [IW-1:0] hd;
        logic [CW-1:0] cnt;
        logic [AW-1:0] sp;
        op_e           pend_op;
        logic [DW-1:0] pend_dat;
        logic          plive;
        logic          uflow;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [IW-1:0] wrap_back(input logic [IW-1:0] base, input int k);
        int t;
        t = (int'(base) + 2 * NREG - k) % NREG;
        return IW'(t);
    endfunction

    logic [IW-1:0] push_idx, nos_idx, bot_idx, fill_idx;
    logic          rf_we;
    logic [IW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rd_top, rd_nos, rd_bot, alu_res;
    logic          do_ev, fin, full;
    op_e           ev_op;
    logic [DW-1:0] ev_dat;
    logic [DEPW-1:0] total, need;

    assign push_idx = wrap_back(s_q.hd, NREG - 1);
    assign nos_idx  = wrap_back(s_q.hd, 1);
    assign bot_idx  = wrap_back(s_q.hd, int'(s_q.cnt) - 1);
    assign fill_idx = wrap_back(s_q.hd, int'(s_q.cnt));
    assign full     = (s_q.cnt == CW'(NREG));
    assign total    = DEPW'(s_q.cnt) + DEPW'(s_q.sp);

    stk_regfile #(.DEPTH(NREG), .DW(DW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .ra_top (s_q.hd),
        .ra_nos (nos_idx),
        .ra_bot (bot_idx),
        .rd_top (rd_top),
        .rd_nos (rd_nos),
        .rd_bot (rd_bot)
    );

    stk_alu #(.DW(DW)) u_alu (
        .op  (ev_op),
        .nos (rd_nos),
        .top (rd_top),
        .res (alu_res)
    );

    stk_counter #(.W(CNTW)) u_store_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (s_q.st == ST_SPILL),
        .count (store_count)
    );

    stk_counter #(.W(CNTW)) u_fetch_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (s_q.st == ST_FREQ),
        .count (fetch_count)
    );

    always_comb begin
        s_d      = s_q;
        rf_we    = 1'b0;
        rf_waddr = push_idx;
        rf_wdata = s_q.pend_dat;
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        mem_addr = s_q.sp;
        do_ev    = 1'b0;
        fin      = 1'b0;
        ev_op    = s_q.pend_op;
        ev_dat   = s_q.pend_dat;

        case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    do_ev  = 1'b1;
                    ev_op  = op_e'(cmd_op);
                    ev_dat = cmd_data;
                end
            end
            ST_SPILL: begin
                // deepest entry goes out, its slot takes the pushed value
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                s_d.sp   = s_q.sp + AW'(1);
                rf_we    = 1'b1;
                rf_waddr = push_idx;
                rf_wdata = s_q.pend_dat;
                s_d.hd   = push_idx;
                s_d.plive = 1'b0;
                s_d.st   = ST_IDLE;
            end
            ST_FREQ: begin
                mem_en   = 1'b1;
                mem_addr = s_q.sp - AW'(1);
                s_d.sp   = s_q.sp - AW'(1);
                s_d.st   = ST_FCAP;
            end
            ST_FCAP: begin
                rf_we    = 1'b1;
                rf_waddr = fill_idx;
                rf_wdata = mem_rdata;
                s_d.cnt  = s_q.cnt + CW'(1);
                s_d.st   = ST_EXEC;
            end
            ST_EXEC: begin
                if (s_q.plive) do_ev = 1'b1;
                else           fin   = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase

        need = (ev_op == OP_POP) ? DEPW'(1) : (is_binary(ev_op) ? DEPW'(2) : DEPW'(0));

        if (do_ev) begin
            if (total < need) begin
                s_d.uflow = 1'b1;
                fin       = 1'b1;
            end else if (ev_op == OP_PUSH && full) begin
                s_d.pend_op  = ev_op;
                s_d.pend_dat = ev_dat;
                s_d.plive    = 1'b1;
                s_d.st       = ST_SPILL;
            end else if (is_binary(ev_op) && s_q.cnt < CW'(2)) begin
                s_d.pend_op  = ev_op;
                s_d.pend_dat = ev_dat;
                s_d.plive    = 1'b1;
                s_d.st       = ST_FREQ;
            end else begin
                fin = 1'b1;
                case (ev_op)
                    OP_PUSH: begin
                        rf_we    = 1'b1;
                        rf_waddr = push_idx;
                        rf_wdata = ev_dat;
                        s_d.hd   = push_idx;
                        s_d.cnt  = s_q.cnt + CW'(1);
                    end
                    OP_POP: begin
                        if (s_q.cnt != '0) begin
                            s_d.hd  = nos_idx;
                            s_d.cnt = s_q.cnt - CW'(1);
                        end else begin
                            s_d.sp = s_q.sp - AW'(1);
                        end
                    end
                    OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                        rf_we    = 1'b1;
                        rf_waddr = nos_idx;
                        rf_wdata = alu_res;
                        s_d.hd   = nos_idx;
                        s_d.cnt  = s_q.cnt - CW'(1);
                    end
                    default: ;
                endcase
            end
        end

        if (fin) begin
            s_d.plive = 1'b0;
            if (EAGER_FILL != 0 && s_d.cnt < CW'(2) && s_d.sp != '0) s_d.st = ST_FREQ;
            else                                                     s_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, hd: '0, cnt: '0, sp: '0, pend_op: OP_PUSH,
                     pend_dat: '0, plive: 1'b0, uflow: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready = (s_q.st == ST_IDLE);
    assign mem_wdata = rd_bot;
    assign tos_valid = (s_q.cnt != '0);
    assign tos_data  = tos_valid ? rd_top : '0;
    assign stk_depth = total;
    assign underflow = s_q.uflow;

    // R8: no memory access while a command can be accepted
    p_ready_low_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !cmd_ready);

    // R4: writes happen only with every register slot occupied
    p_spill_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (s_q.cnt == CW'(NREG)));

    // R5: reads happen only when memory holds entries
    p_fill_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (s_q.sp != '0));

    // R7: flag is sticky
    p_uflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R7: the edge that raises the flag leaves the depth alone
    p_uflow_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $stable(stk_depth));

    // R9: each write is counted once
    p_store_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (store_count == $past(store_count) + CNTW'(1)));

    // R9: each read is counted once
    p_fetch_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (fetch_count == $past(fetch_count) + CNTW'(1)));

    // R1: register occupancy never exceeds the slot count
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(NREG));

endmodule

// File: tb/tb_stack_cache_unit.sv
module tb_stack_cache_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NDUT = 3;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic            cv   [NDUT];
    logic [2:0]      cop  [NDUT];
    logic [DW-1:0]   cdat [NDUT];
    logic            crdy [NDUT];
    logic [DW-1:0]   tos  [NDUT];
    logic            tv   [NDUT];
    logic [AW:0]     dep  [NDUT];
    logic            uf   [NDUT];
    logic [15:0]     sc   [NDUT];
    logic [15:0]     fc   [NDUT];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // dut index 0: two slots lazy, 1: two slots eager, 2: four slots lazy
    for (genvar g = 0; g < NDUT; g++) begin : g_dut
        logic          men, mwe;
        logic [AW-1:0] maddr;
        logic [DW-1:0] mwd, mrd;
        logic [DW-1:0] mem [2**AW];

        always @(posedge clk) begin
            if (men) begin
                if (mwe) mem[maddr] <= mwd;
                else     mrd <= mem[maddr];
            end
        end

        stack_cache_unit #(
            .DW(DW), .NREG((g == 2) ? 4 : 2), .AW(AW), .CNTW(16),
            .EAGER_FILL((g == 1) ? 1 : 0)
        ) dut (
            .clk(clk), .rst_n(rst_n),
            .cmd_valid(cv[g]), .cmd_ready(crdy[g]), .cmd_op(cop[g]), .cmd_data(cdat[g]),
            .tos_data(tos[g]), .tos_valid(tv[g]), .stk_depth(dep[g]), .underflow(uf[g]),
            .store_count(sc[g]), .fetch_count(fc[g]),
            .mem_en(men), .mem_we(mwe), .mem_addr(maddr), .mem_wdata(mwd), .mem_rdata(mrd)
        );
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < NDUT; i++) cv[i] = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_cmd(input int i, input logic [2:0] op, input logic [DW-1:0] v);
        logic acc;
        cv[i] = 1'b1;
        cop[i] = op;
        cdat[i] = v;
        forever begin
            acc = crdy[i];
            @(negedge clk);
            if (acc) break;
        end
        cv[i] = 1'b0;
        while (!crdy[i]) @(negedge clk);
    endtask

    task automatic push(input int i, input logic [DW-1:0] v); do_cmd(i, 3'd0, v); endtask

    task automatic run_expr(input int i, input int exp_traffic);
        push(i, 7); push(i, 3); push(i, 5);
        do_cmd(i, 3'd4, 0); do_cmd(i, 3'd2, 0);
        chk($sformatf("R2 partial dut%0d", i), tos[i], 22);
        push(i, 7); push(i, 2); push(i, 5);
        do_cmd(i, 3'd4, 0); do_cmd(i, 3'd2, 0);
        push(i, 4);
        do_cmd(i, 3'd3, 0); do_cmd(i, 3'd5, 0);
        chk($sformatf("R2 result dut%0d", i), tos[i], 1);
        chk($sformatf("R11 depth dut%0d", i), dep[i], 1);
        chk($sformatf("R10 stores dut%0d", i), sc[i], exp_traffic);
        chk($sformatf("R10 fetches dut%0d", i), fc[i], exp_traffic);
    endtask

    initial begin
        for (int i = 0; i < NDUT; i++) begin cv[i] = 1'b0; cop[i] = '0; cdat[i] = '0; end
        do_reset();

        // R12: reset state
        for (int i = 0; i < NDUT; i++) begin
            chk("R12 ready", crdy[i], 1);
            chk("R12 tos_valid", tv[i], 0);
            chk("R12 depth", dep[i], 0);
            chk("R12 underflow", uf[i], 0);
            chk("R12 stores", sc[i], 0);
            chk("R12 fetches", fc[i], 0);
        end

        // R10: expression stream on each configuration
        run_expr(0, 3);
        run_expr(1, 4);
        run_expr(2, 0);

        // R4 R5 R6 R9 R11: push k values then fold with k-1 adds
        for (int k = 1; k <= 8; k++) begin
            for (int i = 0; i < 2; i++) begin
                int sum;
                int tr;
                do_reset();
                sum = 0;
                for (int j = 0; j < k; j++) begin push(i, 16'(10 + j)); sum += 10 + j; end
                tr = (k > 2) ? k - 2 : 0;
                chk($sformatf("R4 stores k=%0d dut%0d", k, i), sc[i], tr);
                chk($sformatf("R11 depth k=%0d dut%0d", k, i), dep[i], k);
                chk($sformatf("R1 tos k=%0d dut%0d", k, i), tos[i], 10 + k - 1);
                for (int j = 1; j < k; j++) do_cmd(i, 3'd2, 0);
                chk($sformatf("R2 sum k=%0d dut%0d", k, i), tos[i], sum);
                chk($sformatf("R5 fetches k=%0d dut%0d", k, i), fc[i], tr);
            end
        end

        // R8: ready drops while a spill is under way
        do_reset();
        push(0, 1); push(0, 2);
        cv[0] = 1'b1; cop[0] = 3'd0; cdat[0] = 16'd3;
        @(negedge clk);
        cv[0] = 1'b0;
        chk("R8 ready low during spill", crdy[0], 0);
        while (!crdy[0]) @(negedge clk);
        chk("R8 push retired after store", sc[0], 1);
        chk("R8 new top", tos[0], 3);

        // R5 lazy pop on dut0 vs R6 eager pop on dut1
        do_reset();
        for (int i = 0; i < 2; i++) begin push(i, 1); push(i, 2); push(i, 3); do_cmd(i, 3'd1, 0); end
        chk("R5 lazy pop no fetch", fc[0], 0);
        chk("R5 lazy pop tos", tos[0], 2);
        chk("R6 eager pop fetch", fc[1], 1);
        chk("R6 eager pop tos", tos[1], 2);
        chk("R6 eager depth", dep[1], 2);

        // R5: two fills for one subtract, order nos - top
        do_reset();
        push(0, 1); push(0, 2); push(0, 3); push(0, 4);
        do_cmd(0, 3'd1, 0); do_cmd(0, 3'd1, 0);
        chk("R5 empty regs tos_valid", tv[0], 0);
        chk("R5 no fetch on pops", fc[0], 0);
        do_cmd(0, 3'd3, 0);
        chk("R5 two fills", fc[0], 2);
        chk("R2 sub order after fills", tos[0], 16'hFFFF);

        // R5: pop with empty registers discards memory top
        do_reset();
        push(0, 1); push(0, 2); push(0, 3); push(0, 4);
        for (int j = 0; j < 3; j++) do_cmd(0, 3'd1, 0);
        chk("R5 depth after pops", dep[0], 1);
        chk("R5 no fetch after pops", fc[0], 0);
        push(0, 9); do_cmd(0, 3'd2, 0);
        chk("R5 add with fill", tos[0], 10);
        chk("R5 one fetch", fc[0], 1);

        // R2 R3: subtract and divide sweep on dut2
        do_reset();
        for (int x = 0; x < 6; x++) begin
            for (int y = 0; y < 6; y++) begin
                push(2, 16'(x)); push(2, 16'(y)); do_cmd(2, 3'd3, 0);
                chk($sformatf("R2 sub %0d-%0d", x, y), tos[2], 32'((x - y) & 16'hFFFF));
                do_cmd(2, 3'd1, 0);
                push(2, 16'(x)); push(2, 16'(y)); do_cmd(2, 3'd5, 0);
                if (y == 0) chk($sformatf("R3 div %0d/0", x), tos[2], 16'hFFFF);
                else        chk($sformatf("R2 div %0d/%0d", x, y), tos[2], x / y);
                do_cmd(2, 3'd1, 0);
            end
        end
        push(2, 16'h0100); push(2, 16'h0101); do_cmd(2, 3'd4, 0);
        chk("R2 mul truncation", tos[2], 16'h0100);

        // R1: reserved opcodes change nothing
        do_reset();
        push(2, 33);
        do_cmd(2, 3'd6, 5);
        do_cmd(2, 3'd7, 5);
        chk("R1 rsv tos", tos[2], 33);
        chk("R1 rsv depth", dep[2], 1);
        chk("R1 rsv traffic", sc[2] + fc[2], 0);

        // R7: underflow cases
        do_reset();
        do_cmd(2, 3'd1, 0);
        chk("R7 pop empty flag", uf[2], 1);
        chk("R7 pop empty depth", dep[2], 0);
        do_reset();
        chk("R12 flag cleared", uf[2], 0);
        push(2, 5); do_cmd(2, 3'd2, 0);
        chk("R7 add one entry flag", uf[2], 1);
        chk("R7 add one entry tos", tos[2], 5);
        chk("R7 add one entry depth", dep[2], 1);
        push(2, 2); do_cmd(2, 3'd2, 0);
        chk("R7 sticky", uf[2], 1);
        chk("R7 later add ok", tos[2], 7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule